// File: doc/BRIEF.md
# DRAM Read Cycle Sequencer

This block turns a host read request into the strobe and address sequence that reads one word from an asynchronous page-mode DRAM. It runs on an internal clock at twice the bus rate. Each internal cycle is one half of a bus cycle, and the block produces the bus clock itself by toggling a phase bit. This lets every DRAM event land on a chosen half-cycle without using both clock edges.

A request is accepted only at a bus-clock boundary. The block first places the row half of the address on the shared address pins and then drops the row strobe. It then swaps in the column half and drops the byte-lane column strobes chosen by the byte enables. It samples the data pins on a rising bus-clock edge, and the number of half-cycles before that edge depends on the wait-state setting (one or two) latched with the request. After capture the row strobe stays high for a precharge window before the next access may start. The write strobe never asserts, and the block never drives the data pins.

Top module: `dram_rd_seq`

## Requirements
- R1: After reset, ras_n_o, cas_l_n_o and cas_h_n_o are high, ack_o is low and ma_o is zero.
- R2: The row address is on ma_o in the half-cycle before ras_n_o falls and in the first half-cycle it is low; the column address replaces it afterwards.
- R3: From the half-cycle in which ras_n_o falls to the half-cycle in which ack_o is high is 3 half-cycles with wait2_i=0 and 5 with wait2_i=1.
- R4: From the fall of the column strobes to the ack_o half-cycle is 1 half-cycle with wait2_i=0 and 3 with wait2_i=1.
- R5: The column address first appears on ma_o 2 half-cycles (one bus cycle) before the ack_o half-cycle with wait2_i=0, and 4 (two bus cycles) with wait2_i=1.
- R6: ras_n_o stays high for at least 3 half-cycles between accesses, and for exactly 3 when a new request is already pending at the end of an access.
- R7: rdata_o takes dq_i on the rising bus-clock edge that ends the last column-strobe half-cycle; ack_o is high only while bclk_o is high.
- R8: we_n_o stays high and dq_oe_o stays low at all times.
- R9: be_i[0] selects cas_l_n_o and be_i[1] selects cas_h_n_o; an unselected lane stays high through the access.
- R10: ack_o is high for exactly one internal clock per access.
- R11: The row address is addr_i[2*A_W-1:A_W] and the column address is addr_i[A_W-1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the bus rate |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Read request, held until ack_o |
| wait2_i | input | 1 | 1 selects two wait states, 0 selects one |
| be_i | input | 2 | Byte enables: bit 0 low lane, bit 1 high lane |
| addr_i | input | 2*A_W | Word address: row in the upper half, column in the lower half |
| ack_o | output | 1 | One-clock pulse marking data capture |
| rdata_o | output | D_W | Captured read data |
| bclk_o | output | 1 | Generated bus clock |
| ma_o | output | A_W | Multiplexed row/column address |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_l_n_o | output | 1 | Low-lane column strobe, active low |
| cas_h_n_o | output | 1 | High-lane column strobe, active low |
| we_n_o | output | 1 | Write strobe, held inactive |
| dq_oe_o | output | 1 | Data pin drive enable, held off |
| dq_i | input | D_W | DRAM data pins |

## Verification
The bench measures the half-cycle distance from each strobe edge and from the column address swap to the acknowledge, for both wait-state settings. A design that counted bus cycles instead of half-cycles, or that ignored the latched wait setting, shows up as a wrong distance. The data pins carry a poison value except while a column strobe is low, so a capture one half-cycle early or late returns that value instead of the read word. Back-to-back requests check that the precharge gap is exactly three half-cycles: a shorter gap breaks the DRAM, and a longer gap means throughput is lost. Single-lane reads confirm that the unselected column strobe never falls.

// File: rtl/dram_rd_seq.sv
module dram_rd_seq #(
  parameter int A_W = 10,
  parameter int D_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             wait2_i,
  input  logic [1:0]       be_i,
  input  logic [2*A_W-1:0] addr_i,
  output logic             ack_o,
  output logic [D_W-1:0]   rdata_o,
  output logic             bclk_o,
  output logic [A_W-1:0]   ma_o,
  output logic             ras_n_o,
  output logic             cas_l_n_o,
  output logic             cas_h_n_o,
  output logic             we_n_o,
  output logic             dq_oe_o,
  input  logic [D_W-1:0]   dq_i
);
  localparam logic [2:0] CAP_W1 = 3'd4;
  localparam logic [2:0] CAP_W2 = 3'd6;
  localparam logic [2:0] RAS_T  = 3'd1;
  localparam logic [2:0] COL_T  = 3'd2;
  localparam logic [2:0] CAS_T  = 3'd3;

  logic           ph, busy, w2;
  logic [2:0]     t;
  logic [1:0]     be_q;
  logic [A_W-1:0] row_q, col_q;

  logic           nbusy, nw2, start, cap;
  logic [2:0]     nt, ncap, ccap, last;
  logic [1:0]     nbe;
  logic [A_W-1:0] nrow, ncol;

  assign bclk_o  = ~ph;
  assign we_n_o  = 1'b1;
  assign dq_oe_o = 1'b0;

  assign ccap  = w2 ? CAP_W2 : CAP_W1;
  assign last  = ccap + 3'd1;
  assign start = ph && req_i && (!busy || t == last);
  assign cap   = busy && !start && t == ccap - 3'd1;

  assign nw2  = start ? wait2_i : w2;
  assign nbe  = start ? be_i : be_q;
  assign nrow = start ? addr_i[2*A_W-1:A_W] : row_q;
  assign ncol = start ? addr_i[A_W-1:0] : col_q;
  assign ncap = nw2 ? CAP_W2 : CAP_W1;

  always_comb begin
    nbusy = busy;
    nt    = t;
    if (start) begin
      nbusy = 1'b1;
      nt    = 3'd0;
    end else if (busy) begin
      if (t == last) nbusy = 1'b0;
      else           nt = t + 3'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= 1'b0;
      busy      <= 1'b0;
      t         <= 3'd0;
      w2        <= 1'b0;
      be_q      <= 2'b00;
      row_q     <= '0;
      col_q     <= '0;
      ras_n_o   <= 1'b1;
      cas_l_n_o <= 1'b1;
      cas_h_n_o <= 1'b1;
      ma_o      <= '0;
      ack_o     <= 1'b0;
      rdata_o   <= '0;
    end else begin
      ph        <= ~ph;
      busy      <= nbusy;
      t         <= nt;
      w2        <= nw2;
      be_q      <= nbe;
      row_q     <= nrow;
      col_q     <= ncol;
      ras_n_o   <= !(nbusy && nt >= RAS_T && nt < ncap);
      cas_l_n_o <= !(nbusy && nt >= CAS_T && nt < ncap && nbe[0]);
      cas_h_n_o <= !(nbusy && nt >= CAS_T && nt < ncap && nbe[1]);
      ma_o      <= !nbusy ? '0 : (nt < COL_T ? nrow : ncol);
      ack_o     <= cap;
      if (cap) rdata_o <= dq_i;
    end
  end

  logic cas_hi;
  assign cas_hi = cas_l_n_o & cas_h_n_o;

  p_cas_in_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_hi |-> !ras_n_o);
  p_row_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n_o) |-> $stable(ma_o));
  p_precharge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n_o) |=> ras_n_o ##1 ras_n_o);
  p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);
  p_ack_bclk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> bclk_o);
  p_ras_w1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && !w2) |-> (!$past(ras_n_o, 3) && $past(ras_n_o, 4)));
  p_ras_w2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && w2) |-> (!$past(ras_n_o, 5) && $past(ras_n_o, 6)));
  p_cas_w1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && !w2 && |be_q) |-> (!$past(cas_hi, 1) && $past(cas_hi, 2)));
  p_cas_w2_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && w2 && |be_q) |-> (!$past(cas_hi, 3) && $past(cas_hi, 4)));
endmodule

// File: tb/sim_dram_rd_seq.sv
module sim_dram_rd_seq;
  localparam int A_W = 10;
  localparam int D_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_i = 1'b0, wait2_i = 1'b0;
  logic [1:0] be_i = 2'b00;
  logic [2*A_W-1:0] addr_i = '0;
  logic ack_o, bclk_o, ras_n_o, cas_l_n_o, cas_h_n_o, we_n_o, dq_oe_o;
  logic [D_W-1:0] rdata_o, dq_i, cur_data = '0;
  logic [A_W-1:0] ma_o;

  int checks = 0, failures = 0;
  int run = 0, last_run = 0;

  always #10 clk = ~clk;

  assign dq_i = (!cas_l_n_o || !cas_h_n_o) ? cur_data : 16'hDEAD;

  dram_rd_seq #(.A_W(A_W), .D_W(D_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .wait2_i(wait2_i), .be_i(be_i),
    .addr_i(addr_i), .ack_o(ack_o), .rdata_o(rdata_o), .bclk_o(bclk_o),
    .ma_o(ma_o), .ras_n_o(ras_n_o), .cas_l_n_o(cas_l_n_o), .cas_h_n_o(cas_h_n_o),
    .we_n_o(we_n_o), .dq_oe_o(dq_oe_o), .dq_i(dq_i));

  always @(negedge clk) begin
    if (!rst_n) run <= 0;
    else if (ras_n_o) run <= run + 1;
    else if (run != 0) begin
      last_run <= run;
      run <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic do_read(input logic w2, input logic [1:0] be, input logic [19:0] a,
                         input logic [15:0] d, input bit keep, input bit b2b);
    int k = 0, fr = -1, fc = -1, fa = -1;
    bit saw_l = 0, saw_h = 0, pins_ok = 1, bclk_ok = 1;
    logic [A_W-1:0] mas [40];
    logic [A_W-1:0] row = a[19:10];
    logic [A_W-1:0] col = a[9:0];
    int cr, cc;
    cur_data = d; wait2_i = w2; be_i = be; addr_i = a; req_i = 1'b1;
    while (fa < 0 && k < 40) begin
      @(negedge clk);
      mas[k] = ma_o;
      if (fr < 0 && !ras_n_o) fr = k;
      if (fc < 0 && (!cas_l_n_o || !cas_h_n_o)) fc = k;
      if (!cas_l_n_o) saw_l = 1;
      if (!cas_h_n_o) saw_h = 1;
      if (!we_n_o || dq_oe_o) pins_ok = 0;
      if (ack_o) begin
        fa = k;
        if (!bclk_o) bclk_ok = 0;
        if (b2b) chk(last_run == 3, "R6 back-to-back precharge", last_run, 3);
        else     chk(last_run >= 3, "R6 precharge minimum", last_run, 3);
      end
      k++;
    end
    if (!keep) req_i = 1'b0;
    chk(fa >= 0 && fr >= 1, "R3 access completes", fa, 0);
    if (fa >= 0 && fr >= 1) begin
      cr = w2 ? 5 : 3;
      cc = w2 ? 3 : 1;
      chk(fa - fr == cr, "R3 RAS to capture", fa - fr, cr);
      chk(fa - fc == cc, "R4 CAS to capture", fa - fc, cc);
      chk(mas[fr - 1] == row && mas[fr] == row, "R2/R11 row on ma", int'(mas[fr]), int'(row));
      chk(mas[fa - 2*cc + (w2 ? 0 : 0) - (w2 ? 0 : 0) - (w2 ? -2 : 0)] == col,
          "R5/R11 column on ma", int'(mas[fa - (w2 ? 4 : 2)]), int'(col));
      chk(mas[fa - (w2 ? 4 : 2) - 1] == row, "R5 column not early",
          int'(mas[fa - (w2 ? 4 : 2) - 1]), int'(row));
      chk(rdata_o == d, "R7 captured data", int'(rdata_o), int'(d));
      chk(bclk_ok, "R7 ack in bclk high", 0, 1);
      chk(saw_l == be[0] && saw_h == be[1], "R9 lane select",
          int'({saw_h, saw_l}), int'(be));
    end
    chk(pins_ok, "R8 write strobe and drive off", 0, 1);
    @(negedge clk);
    chk(!ack_o, "R10 ack single clock", int'(ack_o), 0);
  endtask

  localparam logic [38:0] VEC [6] = '{
    {1'b0, 2'b11, 20'h12345, 16'hA5A5},
    {1'b1, 2'b11, 20'hFFC01, 16'h5A5A},
    {1'b0, 2'b01, 20'h003FF, 16'h1234},
    {1'b1, 2'b10, 20'hABCDE, 16'hFEDC},
    {1'b1, 2'b01, 20'h80200, 16'h0F0F},
    {1'b0, 2'b10, 20'h7FFFF, 16'hC3C3}
  };

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ras_n_o && cas_l_n_o && cas_h_n_o, "R1 strobes idle in reset", 0, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ras_n_o && cas_l_n_o && cas_h_n_o, "R1 strobes idle", 0, 1);
    chk(!ack_o, "R1 ack low", int'(ack_o), 0);
    chk(ma_o == '0, "R1 ma zero", int'(ma_o), 0);
    chk(we_n_o && !dq_oe_o, "R8 idle pins", 0, 1);
    repeat (3) @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      do_read(VEC[i][38], VEC[i][37:36], VEC[i][35:16], VEC[i][15:0], 1'b0, 1'b0);
      repeat (i % 3) @(negedge clk);
    end

    do_read(1'b0, 2'b11, 20'h0F0F0, 16'h1111, 1'b1, 1'b0);
    do_read(1'b1, 2'b11, 20'hF0F0F, 16'h2222, 1'b1, 1'b1);
    do_read(1'b0, 2'b01, 20'h55555, 16'h3333, 1'b0, 1'b1);

    repeat (5) @(negedge clk);
    chk(ras_n_o && cas_l_n_o && cas_h_n_o && !ack_o, "R10 idle after burst", 0, 1);
    summary();
  end
endmodule